// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Sequencer

This controller-side block owns the SDRAM clock-enable pin and, while a low-power transition is under way, the command bus. A host asks for one of three low-power modes: power-down, self-refresh or clock suspend. It also reports the bank status: all banks idle, or a read/write burst in progress. The block checks the precondition for the chosen mode. It then drops clock enable together with the command that the memory needs at that edge: an AUTO REFRESH for self-refresh, a NOP otherwise. It keeps the memory in that mode until the host raises `wake`.

On wake, clock enable returns high and the block fills the recovery time with NOPs. Power-down and clock suspend recover after a single cycle. Self-refresh recovers after the larger of the `TXSR` parameter and two cycles. `ready` then rises and the command bus is handed back to the host. Each cycle the block decodes the pair of clock-enable values (previous edge, current edge) together with its power state. A combination outside the legal set is flagged on `illegal` and never acted on. A request whose bank-status precondition fails is refused, and this is reported by a single-cycle `err` pulse.

Top module: `sdram_cke_seq`

## Requirements
- R1: After reset `cke`=1, `ready`=1, `cmd`=2'b11 (host owns the bus), `lp_ack`=0, `err`=0 and `illegal`=0.
- R2: A self-refresh request (`lp_req[1]`) taken while `ready`=1, `bank_idle`=1 and `burst_active`=0 gives, at the next clock edge, `cke`=0 and `cmd`=2'b01 (AUTO REFRESH), with `lp_ack[1]` high for exactly that cycle and `ready`=0.
- R3: A power-down request (`lp_req[0]`) under the same bank conditions gives, at the next edge, `cke`=0, `cmd`=2'b00 (NOP), a one-cycle `lp_ack[0]` and `ready`=0.
- R4: A clock-suspend request (`lp_req[2]`) taken while `burst_active`=1 and `bank_idle`=0 gives, at the next edge, `cke`=0, `cmd`=2'b00 (NOP), a one-cycle `lp_ack[2]` and `ready`=0.
- R5: When several requests are pending at once, only the highest-priority one is considered: self-refresh over power-down, and power-down over clock suspend. Only that bit of `lp_ack` can rise.
- R6: While in a low-power mode and without `wake`, `cke` stays 0, `cmd` is 2'b10 (inhibit), `ready` stays 0, and new low-power requests have no effect.
- R7: On `wake` in power-down or clock suspend, the next edge gives `cke`=1 with `cmd`=NOP and `ready`=0 for exactly one cycle. After that, `ready`=1 and `cmd`=2'b11.
- R8: On `wake` in self-refresh, `cke` rises and `cmd` holds NOP with `ready`=0 for exactly max(`TXSR`,2) cycles. After that, `ready`=1 and `cmd`=2'b11.
- R9: A winning request whose precondition fails (power-down or self-refresh without all banks idle, or clock suspend without a burst) is not acknowledged and leaves `cke` high. `err` pulses high for one cycle, one edge later, however long the request is held.
- R10: `wake` while not in a low-power mode, or a pending request with `bank_idle` and `burst_active` both high, drives `illegal` high at the next edge. No mode is entered and `cke` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_req | input | 3 | Held low-power requests: bit0 power-down, bit1 self-refresh, bit2 clock suspend |
| bank_idle | input | 1 | All banks are idle |
| burst_active | input | 1 | A read or write burst is in progress |
| wake | input | 1 | Request to leave the current low-power mode |
| cke | output | 1 | SDRAM clock enable |
| cmd | output | 2 | Command code: 00 NOP, 01 AUTO REFRESH, 10 inhibit, 11 host command passes |
| ready | output | 1 | Normal commands may be issued |
| lp_ack | output | 3 | One-cycle acknowledge, same bit order as `lp_req` |
| err | output | 1 | One-cycle pulse: bank-status precondition not met |
| illegal | output | 1 | Illegal input or clock-enable combination seen; no action taken |

## Verification
Each of the three entries is driven under its own bank status, so the command issued with the falling clock enable separates self-refresh (AUTO REFRESH) from power-down and clock suspend (NOP). The exit lengths separate the one-cycle wake from the self-refresh recovery. Two instances, with a recovery parameter above and below two, show that the minimum of two NOPs is applied. Simultaneous requests show that only the top-priority mode is acknowledged. A power-down request that loses to nothing yet fails its precondition against a pending clock suspend shows that priority is decided before the precondition check. Held failing requests and contradictory bank status tell the single `err` pulse apart from the `illegal` flag.

// File: rtl/sdram_cke_pkg.sv
package sdram_cke_pkg;

  typedef enum logic [2:0] {
    PS_RUN  = 3'd0,
    PS_PDN  = 3'd1,
    PS_SREF = 3'd2,
    PS_SUSP = 3'd3,
    PS_WAKE = 3'd4
  } pstate_t;

  typedef enum logic [2:0] {
    CK_RUN   = 3'd0,
    CK_ENTER = 3'd1,
    CK_HOLD  = 3'd2,
    CK_LEAVE = 3'd3,
    CK_BAD   = 3'd4
  } ckmode_t;

  localparam logic [1:0] CMD_NOP  = 2'b00;
  localparam logic [1:0] CMD_AREF = 2'b01;
  localparam logic [1:0] CMD_INH  = 2'b10;
  localparam logic [1:0] CMD_HOST = 2'b11;

  localparam int REQ_N  = 3;
  localparam int REQ_PD = 0;
  localparam int REQ_SR = 1;
  localparam int REQ_CS = 2;

  // Recovery NOP count after self-refresh: never fewer than two.
  function automatic int unsigned exit_nops(input int unsigned txsr);
    return (txsr > 2) ? txsr : 2;
  endfunction

  // Fixed priority: self-refresh, then power-down, then clock suspend.
  function automatic logic [REQ_N-1:0] pick_winner(input logic [REQ_N-1:0] r);
    logic [REQ_N-1:0] w;
    w = '0;
    if (r[REQ_SR])      w[REQ_SR] = 1'b1;
    else if (r[REQ_PD]) w[REQ_PD] = 1'b1;
    else if (r[REQ_CS]) w[REQ_CS] = 1'b1;
    return w;
  endfunction

  // Bank-status precondition for the winning mode.
  function automatic logic entry_allowed(input logic [REQ_N-1:0] w,
                                         input logic idle,
                                         input logic busy);
    if (w[REQ_CS]) return busy;
    return idle && !busy;
  endfunction

  function automatic logic is_low(input pstate_t s);
    return (s == PS_PDN) || (s == PS_SREF) || (s == PS_SUSP);
  endfunction

  function automatic pstate_t target_of(input logic [REQ_N-1:0] w);
    if (w[REQ_SR]) return PS_SREF;
    if (w[REQ_PD]) return PS_PDN;
    return PS_SUSP;
  endfunction

endpackage

// File: rtl/sdram_cke_arb.sv
module sdram_cke_arb
  import sdram_cke_pkg::*;
(
  input  logic [REQ_N-1:0] req,
  input  logic             bank_idle,
  input  logic             burst_active,
  output logic [REQ_N-1:0] winner,
  output logic             go,
  output logic             fail,
  output logic             clash
);

  logic any_req;
  logic precond;

  always_comb begin
    winner  = pick_winner(req);
    any_req = |req;
    clash   = any_req && bank_idle && burst_active;
    precond = entry_allowed(winner, bank_idle, burst_active);
    go      = any_req && precond && !clash;
    fail    = any_req && !precond && !clash;
  end

endmodule

// File: rtl/sdram_cke_decode.sv
module sdram_cke_decode
  import sdram_cke_pkg::*;
(
  input  logic    cke_prev,
  input  logic    cke_now,
  input  pstate_t state,
  output ckmode_t mode
);

  always_comb begin
    unique case ({cke_prev, cke_now})
      2'b11: mode = (state == PS_RUN || state == PS_WAKE) ? CK_RUN : CK_BAD;
      2'b10: mode = is_low(state) ? CK_ENTER : CK_BAD;
      2'b00: mode = is_low(state) ? CK_HOLD : CK_BAD;
      2'b01: mode = (state == PS_WAKE) ? CK_LEAVE : CK_BAD;
      default: mode = CK_BAD;
    endcase
  end

endmodule

// File: rtl/sdram_cke_exit_timer.sv
module sdram_cke_exit_timer #(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign done = (cnt == CW'(1));

endmodule

// File: rtl/sdram_cke_seq.sv
module sdram_cke_seq
  import sdram_cke_pkg::*;
#(
  parameter int unsigned TXSR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REQ_N-1:0] lp_req,
  input  logic             bank_idle,
  input  logic             burst_active,
  input  logic             wake,
  output logic             cke,
  output logic [1:0]       cmd,
  output logic             ready,
  output logic [REQ_N-1:0] lp_ack,
  output logic             err,
  output logic             illegal
);

  localparam int unsigned NOPS = exit_nops(TXSR);
  localparam int unsigned CW   = $clog2(NOPS + 1);

  pstate_t          state, state_d;
  logic             cke_q, cke_d, cke_prev;
  logic [1:0]       cmd_q, cmd_d;
  logic [REQ_N-1:0] ack_q, ack_d;
  logic             err_q, ill_q, fail_prev;

  logic [REQ_N-1:0] winner;
  logic             arb_go, arb_fail, arb_clash;
  ckmode_t          dec_mode;
  logic             timer_done;
  logic [CW-1:0]    timer_val;

  // Named events for the checker.
  logic             enter_ev, leave_ev, fail_ev, illegal_ev;

  sdram_cke_arb u_arb (
    .req          (lp_req),
    .bank_idle    (bank_idle),
    .burst_active (burst_active),
    .winner       (winner),
    .go           (arb_go),
    .fail         (arb_fail),
    .clash        (arb_clash)
  );

  sdram_cke_decode u_dec (
    .cke_prev (cke_prev),
    .cke_now  (cke_q),
    .state    (state),
    .mode     (dec_mode)
  );

  assign timer_val = (state == PS_SREF) ? CW'(NOPS) : CW'(1);

  sdram_cke_exit_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (leave_ev),
    .load_val (timer_val),
    .done     (timer_done)
  );

  always_comb begin
    illegal_ev = (wake && !is_low(state))
              || ((state == PS_RUN) && arb_clash)
              || (dec_mode == CK_BAD);
    enter_ev   = (state == PS_RUN) && arb_go && !illegal_ev;
    fail_ev    = (state == PS_RUN) && arb_fail && !illegal_ev;
    leave_ev   = is_low(state) && wake;
  end

  always_comb begin
    state_d = state;
    cke_d   = cke_q;
    cmd_d   = CMD_HOST;
    ack_d   = '0;
    unique case (state)
      PS_RUN: begin
        if (enter_ev) begin
          state_d = target_of(winner);
          cke_d   = 1'b0;
          cmd_d   = winner[REQ_SR] ? CMD_AREF : CMD_NOP;
          ack_d   = winner;
        end
      end
      PS_PDN, PS_SREF, PS_SUSP: begin
        if (leave_ev) begin
          state_d = PS_WAKE;
          cke_d   = 1'b1;
          cmd_d   = CMD_NOP;
        end else begin
          cmd_d   = CMD_INH;
        end
      end
      PS_WAKE: begin
        if (timer_done) begin
          state_d = PS_RUN;
          cmd_d   = CMD_HOST;
        end else begin
          cmd_d   = CMD_NOP;
        end
      end
      default: begin
        state_d = PS_RUN;
        cke_d   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= PS_RUN;
      cke_q     <= 1'b1;
      cke_prev  <= 1'b1;
      cmd_q     <= CMD_HOST;
      ack_q     <= '0;
      err_q     <= 1'b0;
      ill_q     <= 1'b0;
      fail_prev <= 1'b0;
    end else begin
      state     <= state_d;
      cke_prev  <= cke_q;
      cke_q     <= cke_d;
      cmd_q     <= cmd_d;
      ack_q     <= ack_d;
      err_q     <= fail_ev && !fail_prev;
      ill_q     <= illegal_ev;
      fail_prev <= fail_ev;
    end
  end

  assign cke     = cke_q;
  assign cmd     = cmd_q;
  assign ready   = (state == PS_RUN);
  assign lp_ack  = ack_q;
  assign err     = err_q;
  assign illegal = ill_q;

endmodule

// File: rtl/sdram_cke_seq_chk.sv
module sdram_cke_seq_chk
  import sdram_cke_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cke,
  input logic [1:0]       cmd,
  input logic             ready,
  input logic [REQ_N-1:0] lp_ack,
  input logic             err,
  input logic             illegal,
  input ckmode_t          mode
);

  // R2
  fell_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (lp_ack != '0));

  // R5
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lp_ack));

  // R2
  aref_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_AREF) |-> (!cke && lp_ack[REQ_SR]));

  // R6
  ready_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> cke);

  // R7
  rise_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (cmd == CMD_NOP && !ready));

  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  // R9
  err_noentry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (lp_ack == '0 && cke));

  // R10
  illegal_noact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (lp_ack == '0 && $stable(cke)));

  // R6
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode != CK_BAD);

endmodule

bind sdram_cke_seq sdram_cke_seq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cke     (cke),
  .cmd     (cmd),
  .ready   (ready),
  .lp_ack  (lp_ack),
  .err     (err),
  .illegal (illegal),
  .mode    (dec_mode)
);

// File: tb/sdram_cke_seq_bench.sv
`timescale 1ns/1ps
module sdram_cke_seq_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] lp_req = 3'b000;
  logic       bank_idle = 1'b1;
  logic       burst_active = 1'b0;
  logic       wake = 1'b0;

  logic       cke, ready, err, illegal;
  logic [1:0] cmd;
  logic [2:0] lp_ack;
  logic       cke_b, ready_b, err_b, illegal_b;
  logic [1:0] cmd_b;
  logic [2:0] lp_ack_b;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sdram_cke_seq #(.TXSR(4)) u_sdram_cke_seq (
    .clk(clk), .rst_n(rst_n), .lp_req(lp_req), .bank_idle(bank_idle),
    .burst_active(burst_active), .wake(wake), .cke(cke), .cmd(cmd),
    .ready(ready), .lp_ack(lp_ack), .err(err), .illegal(illegal)
  );

  sdram_cke_seq #(.TXSR(1)) u_sdram_cke_seq_t1 (
    .clk(clk), .rst_n(rst_n), .lp_req(lp_req), .bank_idle(bank_idle),
    .burst_active(burst_active), .wake(wake), .cke(cke_b), .cmd(cmd_b),
    .ready(ready_b), .lp_ack(lp_ack_b), .err(err_b), .illegal(illegal_b)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk_eq("R1 cke", cke, 1);
    chk_eq("R1 ready", ready, 1);
    chk_eq("R1 cmd", cmd, 3);
    chk_eq("R1 ack", lp_ack, 0);
    chk_eq("R1 err", err, 0);
    chk_eq("R1 illegal", illegal, 0);
  endtask

  task automatic t_selfref();
    int n_a = 0;
    int n_b = 0;
    bank_idle = 1; burst_active = 0; lp_req = 3'b010;
    tick();
    chk_eq("R2 cke", cke, 0);
    chk_eq("R2 cmd AREF", cmd, 1);
    chk_eq("R2 ack", lp_ack, 3'b010);
    chk_eq("R2 ready", ready, 0);
    lp_req = 3'b000;
    tick();
    chk_eq("R2 ack one cycle", lp_ack, 0);
    chk_eq("R6 cmd inhibit", cmd, 2);
    lp_req = 3'b001;
    tick();
    chk_eq("R6 cke held low", cke, 0);
    chk_eq("R6 req ignored", lp_ack, 0);
    chk_eq("R6 ready low", ready, 0);
    lp_req = 3'b000; wake = 1;
    tick();
    wake = 0;
    chk_eq("R8 cke rises", cke, 1);
    for (int i = 0; i < 8; i++) begin
      if (cmd == 2'b00 && !ready) n_a++;
      if (cmd_b == 2'b00 && !ready_b) n_b++;
      tick();
    end
    chk_eq("R8 nop count TXSR=4", n_a, 4);
    chk_eq("R8 nop count TXSR=1", n_b, 2);
    chk_eq("R8 ready", ready, 1);
    chk_eq("R8 cmd host", cmd, 3);
  endtask

  task automatic t_short_mode(input int bitn, input string req);
    lp_req = 3'b000;
    lp_req[bitn] = 1'b1;
    tick();
    chk_eq({req, " cke"}, cke, 0);
    chk_eq({req, " cmd NOP"}, cmd, 0);
    chk_eq({req, " ack"}, lp_ack, 1 << bitn);
    lp_req = 3'b000;
    tick();
    wake = 1;
    tick();
    wake = 0;
    chk_eq("R7 cke rises", cke, 1);
    chk_eq("R7 cmd NOP", cmd, 0);
    chk_eq("R7 ready low", ready, 0);
    tick();
    chk_eq("R7 ready", ready, 1);
    chk_eq("R7 cmd host", cmd, 3);
  endtask

  task automatic t_priority();
    bank_idle = 1; burst_active = 0; lp_req = 3'b111;
    tick();
    chk_eq("R5 sr wins", lp_ack, 3'b010);
    lp_req = 3'b000;
    tick();
    wake = 1;
    tick();
    wake = 0;
    repeat (5) tick();
    chk_eq("R5 back ready", ready, 1);
    // Power-down outranks clock suspend even though only suspend could enter.
    bank_idle = 0; burst_active = 1; lp_req = 3'b101;
    tick();
    chk_eq("R5 no suspend entry", lp_ack, 0);
    chk_eq("R5 cke high", cke, 1);
    chk_eq("R9 err from pd", err, 1);
    lp_req = 3'b000;
    tick();
  endtask

  task automatic t_error();
    bank_idle = 0; burst_active = 1; lp_req = 3'b001;
    tick();
    chk_eq("R9 err pulse", err, 1);
    chk_eq("R9 no ack", lp_ack, 0);
    chk_eq("R9 cke high", cke, 1);
    tick();
    chk_eq("R9 single pulse", err, 0);
    tick();
    chk_eq("R9 still single", err, 0);
    chk_eq("R9 ready", ready, 1);
    lp_req = 3'b000; bank_idle = 1; burst_active = 0;
    tick();
  endtask

  task automatic t_illegal();
    wake = 1;
    tick();
    wake = 0;
    chk_eq("R10 wake while ready", illegal, 1);
    chk_eq("R10 cke", cke, 1);
    tick();
    chk_eq("R10 clears", illegal, 0);
    bank_idle = 1; burst_active = 1; lp_req = 3'b001;
    tick();
    chk_eq("R10 clash flagged", illegal, 1);
    chk_eq("R10 no ack", lp_ack, 0);
    chk_eq("R10 cke high", cke, 1);
    chk_eq("R10 no err", err, 0);
    lp_req = 3'b000; burst_active = 0;
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_selfref();
    t_short_mode(0, "R3");
    bank_idle = 0; burst_active = 1;
    t_short_mode(2, "R4");
    bank_idle = 1; burst_active = 0;
    t_priority();
    t_error();
    t_illegal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule